// File: doc/BRIEF.md
# Half-Step Pulse-Swallow Divider Controller

This block is the digital counter stage that sits behind a dual-modulus prescaler. The prescaler divides the oscillator by 4, or by 4.5 while the modulus-control line is high. The block runs on the prescaler output clock. It takes a 9-bit ratio word in units of one half, with any sigma-delta offset already added. It splits that word into a program count P and a swallow count S, and runs them as one counter per output period. The modulus line is held high for the first S prescaler cycles of the period and low for the remaining P − S cycles. One divided output pulse is issued per P prescaler cycles. The resulting ratio is 4P + 0.5S, which is exactly the ratio word divided by two, in half steps from 36 to 83.5.

A new P/S pair is taken from the ratio word only at the last cycle of a period, so the word may change at any time without disturbing a period already in progress. A word whose P field falls outside the legal range of 9 to 20 is clamped to the nearest limit, and a flag marks the pair that is in use as a clamped one.

Top module: `hsd_divider`

## Requirements
- R1: While reset is asserted and after it is released, the active pair is P = 9, S = 0, the out-of-range flag is low, and the first period is 9 prescaler cycles with the modulus line low throughout.
- R2: The ratio word is decoded as S = word bits [2:0] and P = word bits [8:3], so that 8P + S equals the word and the division ratio is 4P + 0.5S.
- R3: `div_out` is high for exactly one prescaler cycle per period, the last of the P cycles, so that consecutive pulses are P cycles apart.
- R4: `mod_ctrl` is high for the first S prescaler cycles of each period and low for the remaining P − S cycles.
- R5: The ratio word is sampled only at the clock edge that ends a period (the edge after the `div_out` cycle). Changes at any other time do not alter the period in progress, and `active_p`/`active_s` stay constant through a period.
- R6: A word with P below 9 runs with P = 9 and its own S, and raises `range_err` for that period.
- R7: A word with P above 20 runs with P = 20 and its own S, and raises `range_err` for that period.
- R8: `range_err` describes the active pair. It clears when an in-range word is loaded, and P = 9 and P = 20 themselves are in range.
- R9: With S = 0 the modulus line stays low for the whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pre | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ratio_word | input | 9 | Division ratio in half steps (ratio = word / 2) |
| mod_ctrl | output | 1 | Modulus control to the prescaler: high selects divide by 4.5 |
| div_out | output | 1 | One-cycle pulse at the end of each output period |
| active_p | output | 6 | Program count of the period in progress |
| active_s | output | 3 | Swallow count of the period in progress |
| range_err | output | 1 | The active pair came from a clamped word |

## Verification
The bench measures complete periods and counts the cycles and the modulus-high cycles between pulses. A bit-field split done in the wrong place, or a swallow window counted from the end of the period, shows up as a wrong cycle total or as modulus-high cycles that are not at the start of the period. The clamp limits are driven from both sides: words just inside and just outside 9 and 20, a zero word and an all-ones word. A clamp that is off by one, or a flag that sticks or misses, is therefore caught. The ratio word is also changed in the middle of a period. A design that loads early stretches or shortens that period instead of applying the new pair on the next one.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    // Ratio word is counted in half steps; low bits carry the swallow count.
    localparam int RATIO_W = 9;
    localparam int SWAL_W  = 3;
    localparam int PROG_W  = RATIO_W - SWAL_W;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [PROG_W-1:0]  prog_t;
    typedef logic [SWAL_W-1:0]  swal_t;

    // Registered state of the period counter.
    typedef struct packed {
        prog_t phase;   // prescaler cycle index within the period
        prog_t prog;    // active program count
        swal_t swal;    // active swallow count
        logic  clip;    // active pair was clamped
    } ctr_state_t;

endpackage

// File: rtl/hsd_ratio_split.sv
module hsd_ratio_split
    import hsd_pkg::*;
#(
    parameter int P_LO = 9,
    parameter int P_HI = 20
) (
    input  ratio_t ratio,
    output prog_t  prog,
    output swal_t  swal,
    output logic   below,
    output logic   above
);

    prog_t raw_prog;

    always_comb begin
        raw_prog = ratio[RATIO_W-1:SWAL_W];
        swal     = ratio[SWAL_W-1:0];
        below    = raw_prog < prog_t'(P_LO);
        above    = raw_prog > prog_t'(P_HI);
        if (below)
            prog = prog_t'(P_LO);
        else if (above)
            prog = prog_t'(P_HI);
        else
            prog = raw_prog;
    end

endmodule

// File: rtl/hsd_period_ctr.sv
module hsd_period_ctr
    import hsd_pkg::*;
#(
    parameter int P_LO = 9,
    parameter int P_HI = 20
) (
    input  logic  clk,
    input  logic  rst_n,
    input  prog_t nxt_prog,
    input  swal_t nxt_swal,
    input  logic  nxt_clip,
    output logic  mod_hi,
    output logic  term,
    output prog_t cur_prog,
    output swal_t cur_swal,
    output logic  cur_clip
);

    ctr_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        term   = (st_q.phase == (st_q.prog - prog_t'(1)));
        mod_hi = (st_q.phase < prog_t'(st_q.swal));
        if (term) begin
            st_d.phase = '0;
            st_d.prog  = nxt_prog;
            st_d.swal  = nxt_swal;
            st_d.clip  = nxt_clip;
        end else begin
            st_d.phase = st_q.phase + prog_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.prog  <= prog_t'(P_LO);
            st_q.swal  <= '0;
            st_q.clip  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_prog = st_q.prog;
    assign cur_swal = st_q.swal;
    assign cur_clip = st_q.clip;

    // R3
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> !term);

    // R4
    mod_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        term |=> (mod_hi == (cur_swal != '0)));

    // R4
    mod_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mod_hi && !term) |=> !mod_hi);

    // R9
    swal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_swal == '0) |-> !mod_hi);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !term |=> ($stable(cur_prog) && $stable(cur_swal) && $stable(cur_clip)));

    // R6 R7
    prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_prog >= prog_t'(P_LO)) && (cur_prog <= prog_t'(P_HI)));

endmodule

// File: rtl/hsd_divider.sv
module hsd_divider
    import hsd_pkg::*;
#(
    parameter int P_LO = 9,
    parameter int P_HI = 20
) (
    input  logic               clk_pre,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_word,
    output logic               mod_ctrl,
    output logic               div_out,
    output logic [PROG_W-1:0]  active_p,
    output logic [SWAL_W-1:0]  active_s,
    output logic               range_err
);

    prog_t dec_prog;
    swal_t dec_swal;
    logic  dec_below, dec_above;

    hsd_ratio_split #(.P_LO(P_LO), .P_HI(P_HI)) u_split (
        .ratio (ratio_word),
        .prog  (dec_prog),
        .swal  (dec_swal),
        .below (dec_below),
        .above (dec_above)
    );

    hsd_period_ctr #(.P_LO(P_LO), .P_HI(P_HI)) u_ctr (
        .clk      (clk_pre),
        .rst_n    (rst_n),
        .nxt_prog (dec_prog),
        .nxt_swal (dec_swal),
        .nxt_clip (dec_below | dec_above),
        .mod_hi   (mod_ctrl),
        .term     (div_out),
        .cur_prog (active_p),
        .cur_swal (active_s),
        .cur_clip (range_err)
    );

    // R6
    clamp_low_chk: assert property (@(posedge clk_pre) disable iff (!rst_n)
        (div_out && (ratio_word[RATIO_W-1:SWAL_W] < prog_t'(P_LO)))
        |=> (range_err && (active_p == prog_t'(P_LO))));

    // R7
    clamp_high_chk: assert property (@(posedge clk_pre) disable iff (!rst_n)
        (div_out && (ratio_word[RATIO_W-1:SWAL_W] > prog_t'(P_HI)))
        |=> (range_err && (active_p == prog_t'(P_HI))));

    // R2 R8
    load_exact_chk: assert property (@(posedge clk_pre) disable iff (!rst_n)
        (div_out && (ratio_word[RATIO_W-1:SWAL_W] >= prog_t'(P_LO))
                 && (ratio_word[RATIO_W-1:SWAL_W] <= prog_t'(P_HI)))
        |=> (!range_err && ({active_p, active_s} == $past(ratio_word))));

endmodule

// File: tb/hsd_divider_test.sv
module hsd_divider_test;

    logic       clk_pre = 1'b0;
    logic       rst_n   = 1'b0;
    logic [8:0] ratio_word = 9'd0;
    logic       mod_ctrl, div_out, range_err;
    logic [5:0] active_p;
    logic [2:0] active_s;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    hsd_divider uut (
        .clk_pre    (clk_pre),
        .rst_n      (rst_n),
        .ratio_word (ratio_word),
        .mod_ctrl   (mod_ctrl),
        .div_out    (div_out),
        .active_p   (active_p),
        .active_s   (active_s),
        .range_err  (range_err)
    );

    always #2.5 clk_pre = ~clk_pre;

    function automatic int exp_p(input int w);
        int p = w / 8;
        if (p < 9) return 9;
        if (p > 20) return 20;
        return p;
    endfunction

    function automatic int exp_err(input int w);
        int p = w / 8;
        return ((p < 9) || (p > 20)) ? 1 : 0;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_word(input int w);
        @(negedge clk_pre);
        ratio_word = 9'(w);
    endtask

    // Run until the negedge that sees the end-of-period pulse.
    task automatic finish_period();
        for (int i = 0; i < 64; i++) begin
            @(negedge clk_pre);
            if (div_out) break;
        end
    endtask

    // Starts at a pulse negedge; measures the next whole period.
    task automatic check_period(input string req, input int p, input int s, input int err,
                                input int mid_word);
        int cycles = 0;
        int mods = 0;
        int order_bad = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk_pre);
            cycles++;
            if (cycles == 1) begin
                check(req, "active_p", active_p, p);
                check(req, "active_s", active_s, s);
                check(req, "range_err", range_err, err);
            end
            if (mod_ctrl) begin
                mods++;
                if (mods != cycles) order_bad++;
            end
            if (mid_word >= 0 && cycles == 3) ratio_word = 9'(mid_word);
            if (div_out) break;
        end
        check(req, "period cycles", cycles, p);
        check(req, "modulus-high cycles", mods, s);
        check(req, "modulus-high not leading", order_bad, 0);
    endtask

    task automatic run_word(input string req, input int w);
        set_word(w);
        finish_period();
        check_period(req, exp_p(w), w % 8, exp_err(w), -1);
    endtask

    task automatic t_reset();
        int cycles;
        ratio_word = 9'd300;
        rst_n = 1'b0;
        repeat (3) @(negedge clk_pre);
        check("R1", "active_p in reset", active_p, 9);
        check("R1", "active_s in reset", active_s, 0);
        check("R1", "range_err in reset", range_err, 0);
        check("R1", "mod_ctrl in reset", mod_ctrl, 0);
        rst_n = 1'b1;
        cycles = 1;
        check("R1", "div_out first cycle", div_out, 0);
        for (int i = 0; i < 64; i++) begin
            @(negedge clk_pre);
            cycles++;
            if (mod_ctrl) check("R1", "mod_ctrl after reset", 1, 0);
            if (div_out) break;
        end
        check("R1", "first period length", cycles, 9);
    endtask

    task automatic t_decode();
        run_word("R2", 109);   // P13 S5
        run_word("R3", 154);   // P19 S2
        run_word("R4", 86);    // P10 S6
    endtask

    task automatic t_bounds();
        run_word("R9", 72);    // P9 S0
        run_word("R8", 167);   // P20 S7, in range
        run_word("R8", 160);   // P20 S0
        run_word("R8", 79);    // P9 S7
    endtask

    task automatic t_low_clamp();
        run_word("R6", 71);    // P8 S7
        run_word("R6", 0);     // P0 S0
        run_word("R6", 3);     // P0 S3
    endtask

    task automatic t_high_clamp();
        run_word("R7", 168);   // P21 S0
        run_word("R7", 511);   // P63 S7
        run_word("R7", 170);   // P21 S2
    endtask

    task automatic t_flag_clear();
        run_word("R6", 20);    // clamped
        run_word("R8", 100);   // P12 S4, flag clears
    endtask

    task automatic t_mid_change();
        set_word(130);         // P16 S2
        finish_period();
        check_period("R5", 16, 2, 0, 75);   // change to P9 S3 mid-period
        check_period("R5", 9, 3, 0, 505);   // change to clamped word mid-period
        check_period("R5", 20, 1, 1, -1);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk_pre);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_decode();
        t_bounds();
        t_low_clamp();
        t_high_clamp();
        t_flag_clear();
        t_mid_change();
        summary();
    end

endmodule